// File: doc/BRIEF.md
# Near-Segment Row Cache Manager

This block sits in front of the row-activation path of a memory controller. The controller uses a closed-row policy. Each subarray's bitlines are split by an isolation transistor into a short, fast near segment and a long, slow far segment. Out of 512 cells per bitline, 32 rows sit in the near segment and 480 in the far segment. The block treats the near rows of each subarray as an inclusive, fully associative cache of far rows. The far segment always keeps its own copy, so dropping a cached row never needs a write-back.

Each request names a subarray and a far-row index, and is taken with a valid/ready handshake. On a hit, the block issues a near-segment activation with the isolation transistor off.

On a miss, the block runs an in-subarray migration over the shared bitlines:
- It activates the far source row with isolation on. This activation also serves the request.
- `ROW_CYC` cycles later, it activates the chosen near destination row.
- `EXTRA_CYC` cycles after that, it records the new tag and pulses `mig_done`.

The destination row is the least recently used near row of that subarray. No new request is taken while a migration runs.

Top module: `nsc_row_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid`, `mig_done` and `iso_on` are 0. Every near row starts invalid, so the first request to any subarray misses.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the request ends. It returns the cycle after the near command on a hit, and the cycle after `mig_done` on a miss.
- R3: On a hit, one cycle after acceptance, the block issues `cmd_kind`=1 (near activation). `cmd_row` is the near row index that holds the far row, and `iso_on` is 0.
- R4: On a miss, one cycle after acceptance, the block issues `cmd_kind`=2 (migration source, far activation). `cmd_row` is the requested far row and `iso_on` is 1.
- R5: Exactly `ROW_CYC` cycles after the source command, the block issues `cmd_kind`=3 (migration destination). `cmd_row` is the near row being filled and `iso_on` is 1.
- R6: Exactly `EXTRA_CYC` cycles after the destination command, `mig_done` pulses for one cycle with no command. From then on, the same far row in that subarray hits.
- R7: `iso_on` is 1 from the source-command cycle through the cycle before `mig_done`, and 0 in every other cycle.
- R8: Empty near rows are filled in ascending index order, 0 upward. Once all are valid, a miss replaces the least recently used near row. Both hits and fills count as uses.
- R9: Replacing a valid near row adds no command: a miss emits exactly its source and destination commands and nothing else.
- R10: Two back-to-back requests to the same far row start one migration only. The second request waits and then hits the row just filled.
- R11: Subarrays keep separate tag stores. The same far row in another subarray misses there, and `cmd_sub` always equals the request's subarray.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Activation request present |
| req_ready | output | 1 | Block can take a request |
| req_sub | input | SUB_W | Subarray of the request |
| req_row | input | ROW_W | Far-row index of the request |
| cmd_valid | output | 1 | Activation command this cycle |
| cmd_kind | output | 2 | 1 near access, 2 migration source (far), 3 migration destination (near) |
| cmd_sub | output | SUB_W | Subarray of the command |
| cmd_row | output | ROW_W | Row index within the segment selected by `cmd_kind` |
| iso_on | output | 1 | Isolation transistor conducting (far segment connected) |
| mig_done | output | 1 | One-cycle pulse when a migration has finished |

## Verification
The bench counts from the accepting edge A:
- A hit answers in cycle A with a single near command.
- A miss gives its source command in A, its destination command in A+`ROW_CYC` and `mig_done` in A+`ROW_CYC`+`EXTRA_CYC`.
- Isolation must be on across [A, A+`ROW_CYC`+`EXTRA_CYC`).

For each accepted request, the bench queues the expected events with these absolute cycle numbers. The monitor pops and compares them on the falling edge, so the exact cycle is checked. A missing, early, late or extra command is counted as a failure.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

   // Command codes on cmd_kind
   typedef enum logic [1:0] {
      CMD_NONE     = 2'd0,
      CMD_NEAR_ACT = 2'd1,
      CMD_MIG_SRC  = 2'd2,
      CMD_MIG_DST  = 2'd3
   } nsc_cmd_e;

   // Sequencer phases
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_DECIDE = 3'd1,
      PH_WSRC   = 3'd2,
      PH_DST    = 3'd3,
      PH_WMIG   = 3'd4,
      PH_DONE   = 3'd5
   } nsc_phase_e;

endpackage

// File: rtl/nsc_tag_set.sv
// Tag store of one subarray: fully associative match, age-ordered LRU.
module nsc_tag_set #(
   parameter int NEAR_ROWS = 32,
   parameter int ROW_W     = 9,
   parameter int WAY_W     = $clog2(NEAR_ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] look_row,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way,
   output logic [WAY_W-1:0] victim_way,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way,
   input  logic             fill_en,
   input  logic [ROW_W-1:0] fill_row
);

   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NEAR_ROWS - 1);

   logic                 vld_q [NEAR_ROWS];
   logic [ROW_W-1:0]     tag_q [NEAR_ROWS];
   logic [WAY_W-1:0]     age_q [NEAR_ROWS];
   logic [NEAR_ROWS-1:0] match;
   logic [WAY_W-1:0]     touch_age;

   for (genvar w = 0; w < NEAR_ROWS; w++) begin : g_cmp
      assign match[w] = vld_q[w] && (tag_q[w] == look_row);
   end

   assign hit       = |match;
   assign touch_age = age_q[touch_way];

   always_comb begin
      hit_way    = '0;
      victim_way = '0;
      for (int i = 0; i < NEAR_ROWS; i++) begin
         if (match[i])            hit_way    = WAY_W'(i);
         if (age_q[i] == OLDEST)  victim_way = WAY_W'(i);
      end
   end

   // Reset ages make way 0 the oldest, so empty ways fill in ascending order.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NEAR_ROWS; i++) begin
            vld_q[i] <= 1'b0;
            tag_q[i] <= '0;
            age_q[i] <= WAY_W'(NEAR_ROWS - 1 - i);
         end
      end else begin
         for (int i = 0; i < NEAR_ROWS; i++) begin
            if (fill_en && (touch_way == WAY_W'(i))) begin
               vld_q[i] <= 1'b1;
               tag_q[i] <= fill_row;
            end
            if (touch_en) begin
               if (touch_way == WAY_W'(i))    age_q[i] <= '0;
               else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/nsc_seq.sv
// Request/migration sequencer with row-access and extra-migration windows.
module nsc_seq
   import nsc_pkg::*;
#(
   parameter int ROW_CYC   = 4,
   parameter int EXTRA_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       look_hit,
   output logic       req_ready,
   output nsc_phase_e phase
);

   localparam int CMAX = (ROW_CYC > EXTRA_CYC) ? ROW_CYC : EXTRA_CYC;
   localparam int CW   = $clog2(CMAX + 1);

   nsc_phase_e    ph_q;
   logic [CW-1:0] cnt_q;

   assign phase     = ph_q;
   assign req_ready = (ph_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE:   if (req_valid) ph_q <= PH_DECIDE;
            PH_DECIDE: begin
               if (look_hit) ph_q <= PH_IDLE;
               else begin
                  ph_q  <= PH_WSRC;
                  cnt_q <= CW'(ROW_CYC - 2);
               end
            end
            PH_WSRC: begin
               if (cnt_q == '0) ph_q  <= PH_DST;
               else             cnt_q <= cnt_q - 1'b1;
            end
            PH_DST: begin
               ph_q  <= PH_WMIG;
               cnt_q <= CW'(EXTRA_CYC - 2);
            end
            PH_WMIG: begin
               if (cnt_q == '0) ph_q  <= PH_DONE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            PH_DONE:  ph_q <= PH_IDLE;
            default:  ph_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nsc_row_cache.sv
// Near-segment row cache manager (top).
module nsc_row_cache
   import nsc_pkg::*;
#(
   parameter int NUM_SUB   = 4,
   parameter int NEAR_ROWS = 32,
   parameter int FAR_ROWS  = 480,
   parameter int ROW_CYC   = 4,
   parameter int EXTRA_CYC = 2,
   parameter int SUB_W     = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
   parameter int ROW_W     = $clog2(FAR_ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [SUB_W-1:0] req_sub,
   input  logic [ROW_W-1:0] req_row,
   output logic             cmd_valid,
   output logic [1:0]       cmd_kind,
   output logic [SUB_W-1:0] cmd_sub,
   output logic [ROW_W-1:0] cmd_row,
   output logic             iso_on,
   output logic             mig_done
);

   localparam int WAY_W = $clog2(NEAR_ROWS);

   if (NEAR_ROWS < 2)         begin : g_e1 $error("NEAR_ROWS must be at least 2"); end
   if (NEAR_ROWS > FAR_ROWS)  begin : g_e2 $error("near segment larger than far segment"); end
   if (ROW_CYC < 2)           begin : g_e3 $error("ROW_CYC must be at least 2"); end
   if (EXTRA_CYC < 2)         begin : g_e4 $error("EXTRA_CYC must be at least 2"); end
   if (NUM_SUB < 1)           begin : g_e5 $error("NUM_SUB must be at least 1"); end

   nsc_phase_e       ph;
   logic [SUB_W-1:0] sub_q;
   logic [ROW_W-1:0] row_q;
   logic [WAY_W-1:0] way_q;
   logic             sel_hit;
   logic [WAY_W-1:0] sel_hway, sel_vict;

   logic             hit_s  [NUM_SUB];
   logic [WAY_W-1:0] hway_s [NUM_SUB];
   logic [WAY_W-1:0] vict_s [NUM_SUB];

   wire req_fire = req_valid && req_ready;
   wire in_done  = (ph == PH_DONE);

   nsc_seq #(.ROW_CYC(ROW_CYC), .EXTRA_CYC(EXTRA_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .look_hit  (sel_hit),
      .req_ready (req_ready),
      .phase     (ph)
   );

   for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
      wire              mine  = (sub_q == SUB_W'(s));
      wire              t_en  = mine && (((ph == PH_DECIDE) && hit_s[s]) || in_done);
      wire [WAY_W-1:0]  t_way = in_done ? way_q : hway_s[s];
      nsc_tag_set #(.NEAR_ROWS(NEAR_ROWS), .ROW_W(ROW_W), .WAY_W(WAY_W)) u_tags (
         .clk        (clk),
         .rst_n      (rst_n),
         .look_row   (row_q),
         .hit        (hit_s[s]),
         .hit_way    (hway_s[s]),
         .victim_way (vict_s[s]),
         .touch_en   (t_en),
         .touch_way  (t_way),
         .fill_en    (mine && in_done),
         .fill_row   (row_q)
      );
   end

   always_comb begin
      sel_hit  = 1'b0;
      sel_hway = '0;
      sel_vict = '0;
      for (int s = 0; s < NUM_SUB; s++) begin
         if (sub_q == SUB_W'(s)) begin
            sel_hit  = hit_s[s];
            sel_hway = hway_s[s];
            sel_vict = vict_s[s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         row_q <= '0;
         way_q <= '0;
      end else begin
         if (req_fire) begin
            sub_q <= req_sub;
            row_q <= req_row;
         end
         if ((ph == PH_DECIDE) && !sel_hit) way_q <= sel_vict;
      end
   end

   always_comb begin
      cmd_valid = 1'b0;
      cmd_kind  = CMD_NONE;
      cmd_row   = '0;
      if (ph == PH_DECIDE) begin
         cmd_valid = 1'b1;
         cmd_kind  = sel_hit ? CMD_NEAR_ACT : CMD_MIG_SRC;
         cmd_row   = sel_hit ? ROW_W'(sel_hway) : row_q;
      end else if (ph == PH_DST) begin
         cmd_valid = 1'b1;
         cmd_kind  = CMD_MIG_DST;
         cmd_row   = ROW_W'(way_q);
      end
   end

   assign cmd_sub  = sub_q;
   assign mig_done = in_done;
   assign iso_on   = ((ph == PH_DECIDE) && !sel_hit) || (ph == PH_WSRC) ||
                     (ph == PH_DST) || (ph == PH_WMIG);

endmodule

// File: rtl/nsc_row_cache_chk.sv
// Protocol checker bound to the top module.
module nsc_row_cache_chk #(
   parameter int ROW_CYC   = 4,
   parameter int EXTRA_CYC = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       cmd_valid,
   input logic [1:0] cmd_kind,
   input logic       iso_on,
   input logic       mig_done
);

   localparam int GW = $clog2(ROW_CYC + EXTRA_CYC + 2) + 1;
   localparam logic [GW-1:0] GMAX = {GW{1'b1}};

   logic [GW-1:0] src_gap, dst_gap;

   wire is_src = cmd_valid && (cmd_kind == 2'd2);
   wire is_dst = cmd_valid && (cmd_kind == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_gap <= '0;
         dst_gap <= '0;
      end else begin
         if (is_src)                                 src_gap <= GW'(1);
         else if (src_gap != '0 && src_gap != GMAX)  src_gap <= src_gap + 1'b1;
         if (is_dst)                                 dst_gap <= GW'(1);
         else if (dst_gap != '0 && dst_gap != GMAX)  dst_gap <= dst_gap + 1'b1;
      end
   end

   a_r3_near_iso_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'd1) |-> !iso_on);

   a_r7_mig_iso_on: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind[1]) |-> iso_on);

   a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid || mig_done || iso_on) |-> !req_ready);

   a_r5_dst_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      is_dst |-> (src_gap == GW'(ROW_CYC)));

   a_r6_done_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      mig_done |-> (dst_gap == GW'(EXTRA_CYC) && !cmd_valid));

   a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      mig_done |=> req_ready);

   a_r1_kind_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_kind != 2'd0));

endmodule

bind nsc_row_cache nsc_row_cache_chk #(.ROW_CYC(ROW_CYC), .EXTRA_CYC(EXTRA_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .cmd_valid (cmd_valid),
   .cmd_kind  (cmd_kind),
   .iso_on    (iso_on),
   .mig_done  (mig_done)
);

// File: tb/nsc_row_cache_bench.sv
`timescale 1ns/1ps
module nsc_row_cache_bench;

   localparam int NSUB  = 4;
   localparam int NEAR  = 32;
   localparam int FAR   = 480;
   localparam int ROWC  = 4;
   localparam int EXTC  = 2;
   localparam int SUB_W = 2;
   localparam int ROW_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [SUB_W-1:0] req_sub = '0;
   logic [ROW_W-1:0] req_row = '0;
   logic             cmd_valid;
   logic [1:0]       cmd_kind;
   logic [SUB_W-1:0] cmd_sub;
   logic [ROW_W-1:0] cmd_row;
   logic             iso_on;
   logic             mig_done;

   always #10 clk = ~clk;

   nsc_row_cache #(.NUM_SUB(NSUB), .NEAR_ROWS(NEAR), .FAR_ROWS(FAR),
                   .ROW_CYC(ROWC), .EXTRA_CYC(EXTC)) u_nsc_row_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_sub(req_sub), .req_row(req_row), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cmd_sub(cmd_sub), .cmd_row(cmd_row),
      .iso_on(iso_on), .mig_done(mig_done));

   typedef struct {
      int    kind;   // 1 near, 2 source, 3 destination, 4 done pulse
      int    sub;
      int    row;
      bit    iso;
      int    cyc;
      string tag;
   } exp_t;

   exp_t  sbq[$];
   int    n_chk = 0, n_fail = 0;
   int    cyc = 0;
   int    iso_lo = 0, iso_hi = 0;
   bit    finished = 1'b0;
   string cur_tag = "R1";

   // independent model: valid, tag and last-use stamp per near row
   bit vld_m [NSUB][NEAR];
   int tag_m [NSUB][NEAR];
   int lu_m  [NSUB][NEAR];
   int stamp = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string tag, string msg);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   task automatic take_event(int kind, int s, int r, bit iso);
      exp_t e;
      if (sbq.size() == 0) begin
         chk(1'b0, "R9", $sformatf("unexpected event kind=%0d sub=%0d row=%0d at cyc %0d, expected none",
                                  kind, s, r, cyc));
         return;
      end
      e = sbq.pop_front();
      chk(kind == e.kind && s == e.sub && (kind == 4 || r == e.row) && iso == e.iso && cyc == e.cyc,
          e.tag,
          $sformatf("actual kind=%0d sub=%0d row=%0d iso=%0d cyc=%0d, expected kind=%0d sub=%0d row=%0d iso=%0d cyc=%0d",
                    kind, s, r, iso, cyc, e.kind, e.sub, e.row, e.iso, e.cyc));
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(iso_on == (cyc >= iso_lo && cyc < iso_hi), "R7",
             $sformatf("iso_on actual %0d expected %0d at cyc %0d",
                       iso_on, (cyc >= iso_lo && cyc < iso_hi), cyc));
         if (cmd_valid) take_event(int'(cmd_kind), int'(cmd_sub), int'(cmd_row), iso_on);
         if (mig_done)  take_event(4, int'(cmd_sub), 0, iso_on);
      end
   end

   // driver: presents the request, predicts every resulting event
   task automatic send(int s, int r);
      int acc, way, vic;
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1;
      req_sub   = SUB_W'(s);
      req_row   = ROW_W'(r);
      while (!req_ready) @(negedge clk);
      acc = cyc + 1;
      way = -1;
      for (int w = 0; w < NEAR; w++) if (vld_m[s][w] && tag_m[s][w] == r) way = w;
      if (way >= 0) begin
         e = '{kind:1, sub:s, row:way, iso:1'b0, cyc:acc, tag:{cur_tag, "/R3"}};
         sbq.push_back(e);
         lu_m[s][way] = stamp++;
      end else begin
         vic = 0;
         for (int w = 1; w < NEAR; w++) if (lu_m[s][w] < lu_m[s][vic]) vic = w;
         e = '{kind:2, sub:s, row:r, iso:1'b1, cyc:acc, tag:{cur_tag, "/R4"}};
         sbq.push_back(e);
         e = '{kind:3, sub:s, row:vic, iso:1'b1, cyc:acc + ROWC, tag:{cur_tag, "/R5"}};
         sbq.push_back(e);
         e = '{kind:4, sub:s, row:0, iso:1'b0, cyc:acc + ROWC + EXTC, tag:{cur_tag, "/R6"}};
         sbq.push_back(e);
         iso_lo = acc;
         iso_hi = acc + ROWC + EXTC;
         vld_m[s][vic] = 1'b1;
         tag_m[s][vic] = r;
         lu_m[s][vic]  = stamp++;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R2", $sformatf("req_ready actual %0d expected 0 after acceptance", req_ready));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      int x;
      for (int s = 0; s < NSUB; s++)
         for (int w = 0; w < NEAR; w++) begin
            vld_m[s][w] = 1'b0;
            tag_m[s][w] = 0;
            lu_m[s][w]  = w - 1000;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", $sformatf("req_ready actual %0d expected 1", req_ready));
      chk(cmd_valid == 1'b0, "R1", $sformatf("cmd_valid actual %0d expected 0", cmd_valid));
      chk(mig_done == 1'b0,  "R1", $sformatf("mig_done actual %0d expected 0", mig_done));
      chk(iso_on == 1'b0,    "R1", $sformatf("iso_on actual %0d expected 0", iso_on));

      // first request misses (R1), migration sequence R4 R5 R6, then hit R3
      cur_tag = "R1";
      send(0, 5);
      cur_tag = "R3";
      send(0, 5);

      // R10: back-to-back same row, second waits then hits
      cur_tag = "R10";
      send(1, 7);
      send(1, 7);

      // R11: far row cached in subarray 0 still misses in subarray 1
      cur_tag = "R11";
      send(1, 5);
      send(0, 5);

      // R8: fill order, then LRU replacement with a refresh by hit; R9 no write-back
      cur_tag = "R8";
      for (int i = 0; i < NEAR; i++) send(2, 100 + i);
      send(2, 100);
      cur_tag = "R9";
      send(2, 200);
      send(2, 101);
      send(2, 100);

      // mixed pattern over two subarrays
      cur_tag = "R8";
      x = 3;
      for (int i = 0; i < 60; i++) begin
         x = (x * 13 + 7) % 41;
         send((i % 2 == 0) ? 3 : 0, 300 + x);
      end

      repeat (ROWC + EXTC + 4) @(negedge clk);
      chk(sbq.size() == 0, "R6", $sformatf("pending events actual %0d expected 0", sbq.size()));
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      @(negedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not end, actual cycle %0d expected below 200000", cyc);
         finish_run();
      end
   end

endmodule